// File: doc/BRIEF.md
# Chained Buffer-Descriptor DMA Channel

This block is one DMA channel that follows a chain of buffer descriptors kept in system memory. A pulse on `start` hands it the address of the first descriptor. For each descriptor the channel reads four words: control, source address, destination address and the address of the following descriptor. It then copies the requested number of 32-bit words from source to destination. Each word moves only when the peripheral signals that it is ready. After each word the source and destination pointers are stepped as the control word directs.

The channel also carries a short command/status byte for the peripheral. The byte is presented with a one-cycle strobe when the first word of a buffer has moved. When a buffer is marked as the last of a frame, the channel asks the peripheral for a status byte, puts it in place of the command byte and writes the control word back into the descriptor. At the end of each buffer the channel may raise a one-cycle interrupt. It then either moves to the next descriptor or stops. The next descriptor is found either 16 bytes further on or at the address the descriptor names. The channel never gives any meaning to the command/status bits.

Top module: `lldma_engine`

## Requirements
- R1: After a start, the channel reads four words at the descriptor address, at offsets 0, 4, 8 and 12: control, source, destination, next address. The control word layout is: bits 15:0 word count, bits 17:16 source step mode, bits 19:18 destination step mode, bit 20 interrupt-at-end, bit 21 jump-to-next, bit 22 end-of-frame, bit 23 stop-after, bits 31:24 command/status byte.
- R2: Each data word is read from the source address and then written to the destination address. A word starts only while `per_req` is high. `per_ack` pulses once per word, when that word's write is acknowledged. A memory request stays asserted, with a stable address, until `mem_ack` returns.
- R3: Source step mode 00 keeps the source address fixed. Mode 01 adds 4 after each word. Mode 10 subtracts 4 after each word.
- R4: Destination step mode uses the same encoding as R3: 00 fixed, 01 plus 4, 10 minus 4.
- R5: Step mode 11 in either field leaves that address fixed. It also sets `err`, which then stays high until reset.
- R6: At the end of a buffer, `irq` pulses high for exactly one cycle if bit 20 is 1. If bit 20 is 0, no pulse is given for that buffer.
- R7: At the end of a buffer, if bit 21 is 0 the descriptor address advances by 16. If bit 21 is 1, it is loaded with the descriptor's next-address word.
- R8: If bit 23 is 1, the channel stops after the buffer and `busy` falls. If bit 23 is 0, it fetches the next descriptor.
- R9: `cmd_data` shows bits 31:24 of the control word. `cmd_valid` is high for exactly one cycle, in the same cycle as the `per_ack` of the first word of each buffer.
- R10: If bit 22 is 1, after the last data word the channel holds `stat_req` until `stat_ack`. It stores `stat_data` in bits 31:24, then writes the whole control word back to offset 0 of the descriptor.
- R11: A descriptor with a word count of 0 moves no data and gives no `cmd_valid` strobe. The end-of-buffer actions of R6, R7, R8 and R10 still apply.
- R12: `busy` is high from an accepted start until the stop of R8. A start pulse while `busy` is high is ignored.
- R13: After reset, `busy`, `irq`, `err`, `cmd_valid`, `per_ack`, `mem_req` and `stat_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start pulse, sampled when idle |
| start_addr | input | 32 | Address of the first descriptor |
| busy | output | 1 | Channel is walking a chain |
| irq | output | 1 | One-cycle end-of-buffer interrupt |
| err | output | 1 | Sticky reserved-step-mode flag |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| per_req | input | 1 | Peripheral ready for a word |
| per_ack | output | 1 | One-cycle pulse per moved word |
| cmd_valid | output | 1 | Command byte strobe on the first word |
| cmd_data | output | 8 | Command/status byte of the current descriptor |
| stat_req | output | 1 | Status request for an end-of-frame buffer |
| stat_ack | input | 1 | Status byte valid |
| stat_data | input | 8 | Status byte from the peripheral |

## Verification
The hardest situation to reach from the ports is a single run that goes through both ways of finding the next descriptor. The same run must end with a status write-back whose value comes from the peripheral. The stimulus builds a three-descriptor chain. The first link is contiguous, the second jumps to a distant address, and the last is an end-of-frame buffer that stops the channel. A scoreboard predicts every memory write, including the written-back control word. The run starts with `per_req` held low, to show that nothing moves while the peripheral is not ready. A second start is sent in the middle of the run, and the prediction must still match.

// File: rtl/lldma_pkg.sv
// Shared types for the chained DMA channel.
// Assumes nothing beyond the users importing it.
package lldma_pkg;

    // Pointer step selection carried in the control word.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10,
        STEP_RSVD = 2'b11
    } step_mode_t;

    // Channel sequencer states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_STAT,
        ST_WBACK,
        ST_FINISH
    } eng_state_t;

endpackage

// File: rtl/lldma_addr_step.sv
// Computes the address after one word transfer for a given step mode.
// Assumes the caller applies the result only when a word completes.
module lldma_addr_step
    import lldma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] cur_addr,
    input  step_mode_t    mode,
    output logic [AW-1:0] nxt_addr,
    output logic          rsvd
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    // Select the stepped address; the reserved code behaves as hold.
    always_comb begin
        rsvd = 1'b0;
        unique case (mode)
            STEP_UP:   nxt_addr = cur_addr + STEP_V;
            STEP_DOWN: nxt_addr = cur_addr - STEP_V;
            STEP_RSVD: begin
                nxt_addr = cur_addr;
                rsvd     = 1'b1;
            end
            default:   nxt_addr = cur_addr;
        endcase
    end
endmodule

// File: rtl/lldma_word_count.sv
// Remaining-word counter for one buffer.
// Assumes load and dec are never high in the same cycle.
module lldma_word_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last,
    output logic          zero
);
    logic [CW-1:0] remaining;

    // Hold the number of words still to move in the current buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)    remaining <= '0;
        else if (load) remaining <= load_val;
        else if (dec)  remaining <= remaining - CW'(1);
    end

    // Flag the final word and the empty buffer.
    always_comb begin
        last = (remaining == CW'(1));
        zero = (remaining == '0);
    end
endmodule

// File: rtl/lldma_engine.sv
// Chained buffer-descriptor DMA channel: fetches four-word descriptors,
// moves words gated by the peripheral, strobes the command byte, collects
// status on end-of-frame buffers and writes it back, then chains or stops.
// Assumes a memory that holds each request until it returns mem_ack with
// read data in the same cycle, and DW == CW + 8 + FW.
module lldma_engine
    import lldma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int CW         = 16,
    parameter int FW         = 8,
    parameter int WORD_BYTES = 4,
    parameter int LIST_STEP  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    output logic          busy,
    output logic          irq,
    output logic          err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          per_req,
    output logic          per_ack,
    output logic          cmd_valid,
    output logic [FW-1:0] cmd_data,
    output logic          stat_req,
    input  logic          stat_ack,
    input  logic [FW-1:0] stat_data
);
    localparam int SMODE_LSB = CW;
    localparam int DMODE_LSB = CW + 2;
    localparam int IEOB_BIT  = CW + 4;
    localparam int JUMP_BIT  = CW + 5;
    localparam int EOF_BIT   = CW + 6;
    localparam int HALT_BIT  = CW + 7;
    localparam int FIELD_LSB = CW + 8;
    localparam int NPTR      = 2;

    eng_state_t    state;
    logic [AW-1:0] list_addr;
    logic [DW-1:0] ctrl_q;
    logic [AW-1:0] next_q;
    logic [DW-1:0] hold_q;
    logic [1:0]    fidx;
    logic          first_q;

    logic [AW-1:0] ptr_q   [NPTR];
    logic [AW-1:0] ptr_nxt [NPTR];
    step_mode_t    ptr_mode[NPTR];
    logic          ptr_rsvd[NPTR];

    logic cnt_load, cnt_dec, cnt_last, cnt_zero;

    // Source (0) and destination (1) pointers share one stepper design.
    for (genvar p = 0; p < NPTR; p++) begin : g_ptr
        assign ptr_mode[p] = step_mode_t'(ctrl_q[SMODE_LSB + 2*p +: 2]);
        lldma_addr_step #(.AW(AW), .STEP(WORD_BYTES)) u_step (
            .cur_addr (ptr_q[p]),
            .mode     (ptr_mode[p]),
            .nxt_addr (ptr_nxt[p]),
            .rsvd     (ptr_rsvd[p])
        );
    end

    lldma_word_count #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (ctrl_q[CW-1:0]),
        .dec      (cnt_dec),
        .last     (cnt_last),
        .zero     (cnt_zero)
    );

    // Counter is loaded when a descriptor is checked and counts written words.
    always_comb begin
        cnt_load = (state == ST_CHECK);
        cnt_dec  = (state == ST_WRITE) && mem_ack;
    end

    // Drive the memory master port from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = list_addr;
        mem_wdata = ctrl_q;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = list_addr + AW'(fidx) * AW'(WORD_BYTES);
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q[0];
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q[1];
                mem_wdata = hold_q;
            end
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // Status-side and visible flags that follow the state directly.
    always_comb begin
        busy     = (state != ST_IDLE);
        stat_req = (state == ST_STAT);
        cmd_data = ctrl_q[FIELD_LSB +: FW];
    end

    // Main sequencer: fetch, transfer, status, write-back, chain or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            list_addr <= '0;
            ctrl_q    <= '0;
            next_q    <= '0;
            hold_q    <= '0;
            fidx      <= '0;
            first_q   <= 1'b0;
            ptr_q[0]  <= '0;
            ptr_q[1]  <= '0;
            irq       <= 1'b0;
            err       <= 1'b0;
            per_ack   <= 1'b0;
            cmd_valid <= 1'b0;
        end else begin
            irq       <= 1'b0;
            per_ack   <= 1'b0;
            cmd_valid <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    list_addr <= start_addr;
                    fidx      <= '0;
                    state     <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    unique case (fidx)
                        2'd0: ctrl_q   <= mem_rdata;
                        2'd1: ptr_q[0] <= mem_rdata[AW-1:0];
                        2'd2: ptr_q[1] <= mem_rdata[AW-1:0];
                        default: next_q <= mem_rdata[AW-1:0];
                    endcase
                    fidx <= fidx + 2'd1;
                    if (fidx == 2'd3) state <= ST_CHECK;
                end
                ST_CHECK: begin
                    first_q <= 1'b1;
                    if (ptr_rsvd[0] || ptr_rsvd[1]) err <= 1'b1;
                    if (ctrl_q[CW-1:0] != '0) state <= ST_WAIT;
                    else if (ctrl_q[EOF_BIT]) state <= ST_STAT;
                    else                      state <= ST_FINISH;
                end
                ST_WAIT: if (per_req) state <= ST_READ;
                ST_READ: if (mem_ack) begin
                    hold_q <= mem_rdata;
                    state  <= ST_WRITE;
                end
                ST_WRITE: if (mem_ack) begin
                    per_ack   <= 1'b1;
                    cmd_valid <= first_q;
                    first_q   <= 1'b0;
                    ptr_q[0]  <= ptr_nxt[0];
                    ptr_q[1]  <= ptr_nxt[1];
                    if (!cnt_last && !cnt_zero) state <= ST_WAIT;
                    else if (ctrl_q[EOF_BIT])   state <= ST_STAT;
                    else                        state <= ST_FINISH;
                end
                ST_STAT: if (stat_ack) begin
                    ctrl_q[FIELD_LSB +: FW] <= stat_data;
                    state <= ST_WBACK;
                end
                ST_WBACK: if (mem_ack) state <= ST_FINISH;
                ST_FINISH: begin
                    irq       <= ctrl_q[IEOB_BIT];
                    list_addr <= ctrl_q[JUMP_BIT] ? next_q
                                                  : list_addr + AW'(LIST_STEP);
                    fidx      <= '0;
                    state     <= ctrl_q[HALT_BIT] ? ST_IDLE : ST_FETCH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lldma_engine_chk.sv
// Protocol and strobe checks for lldma_engine, attached by bind.
// Assumes the memory and status responders follow a hold-until-ack rule.
module lldma_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          irq,
    input logic          err,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          per_ack,
    input logic          cmd_valid,
    input logic          stat_req,
    input logic          stat_ack
);
    // R6: the interrupt is a single-cycle pulse.
    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: the command strobe is a single cycle wide.
    assert_cmd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R9: the command strobe coincides with a moved word.
    assert_cmd_with_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> per_ack);

    // R2: a pending memory request keeps its address until acknowledged.
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R12: an idle channel issues no memory or status request.
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !stat_req));

    // R5: the error flag is sticky.
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R10: a status request is held until answered.
    assert_stat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_req && !stat_ack) |=> stat_req);
endmodule

bind lldma_engine lldma_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/lldma_engine_tb_top.sv
// Scoreboard bench: descriptor builder predicts writes and command bytes,
// a monitor compares them against the memory port as they occur.
module lldma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        busy, irq, err;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        per_req = 1'b0;
    logic        per_ack, cmd_valid, stat_req;
    logic [7:0]  cmd_data;
    logic        stat_ack = 1'b0;
    logic [7:0]  stat_data = 8'hC7;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int irq_seen = 0;
    int ack_seen = 0;
    int wr_seen = 0;
    int exp_irq = 0;
    int exp_ack = 0;
    logic exp_err = 1'b0;
    logic [63:0] exp_wr_q[$];
    logic [7:0]  exp_cmd_q[$];
    logic [31:0] mem [0:255];

    always #2 clk = ~clk;

    lldma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .busy(busy), .irq(irq), .err(err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .per_req(per_req), .per_ack(per_ack),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .stat_req(stat_req), .stat_ack(stat_ack), .stat_data(stat_data)
    );

    // Memory responder: acknowledge one cycle after a request.
    always @(posedge clk) begin
        mem_ack   <= mem_req && !mem_ack;
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_req && mem_we && !mem_ack) mem[mem_addr[9:2]] <= mem_wdata;
        stat_ack  <= stat_req && !stat_ack;
    end

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare as writes and command strobes appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_ack && mem_we) begin
                wr_seen++;
                if (exp_wr_q.size() == 0)
                    check(0, "R2 unexpected write", {mem_addr, mem_wdata}, '0);
                else begin
                    automatic logic [63:0] e = exp_wr_q.pop_front();
                    check({mem_addr, mem_wdata} == e, "R2/R3/R4/R10 write",
                          {mem_addr, mem_wdata}, e);
                end
            end
            if (cmd_valid) begin
                if (exp_cmd_q.size() == 0)
                    check(0, "R9/R11 unexpected cmd", 64'(cmd_data), '0);
                else begin
                    automatic logic [7:0] c = exp_cmd_q.pop_front();
                    check(cmd_data == c, "R9 cmd byte", 64'(cmd_data), 64'(c));
                end
                check(per_ack, "R9 cmd with first word", 64'(per_ack), 64'd1);
            end
            if (irq) irq_seen++;
            if (per_ack) ack_seen++;
        end
    end

    function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] m);
        if (m == 2'b01) return a + 32'd4;
        if (m == 2'b10) return a - 32'd4;
        return a;
    endfunction

    // Driver: place a descriptor in memory and push the predicted results.
    task automatic build_desc(input logic [31:0] base, input logic [15:0] cnt,
                              input logic [1:0] sm, input logic [1:0] dm,
                              input bit ieob, input bit jump, input bit eof,
                              input bit halt, input logic [7:0] cmd,
                              input logic [31:0] src, input logic [31:0] dst,
                              input logic [31:0] nxt);
        logic [31:0] ctrl;
        logic [31:0] s, d;
        ctrl = {cmd, halt, eof, jump, ieob, dm, sm, cnt};
        mem[base[9:2]]     = ctrl;
        mem[base[9:2] + 1] = src;
        mem[base[9:2] + 2] = dst;
        mem[base[9:2] + 3] = nxt;
        s = src;
        d = dst;
        for (int i = 0; i < int'(cnt); i++) begin
            exp_wr_q.push_back({d, mem[s[9:2]]});
            s = step(s, sm);
            d = step(d, dm);
        end
        if (cnt != 0) exp_cmd_q.push_back(cmd);
        if (eof) exp_wr_q.push_back({base, {stat_data, ctrl[23:0]}});
        if (ieob) exp_irq++;
        if (sm == 2'b11 || dm == 2'b11) exp_err = 1'b1;
        exp_ack += int'(cnt);
    endtask

    task automatic pulse_start(input logic [31:0] a);
        @(negedge clk);
        start_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + 32'(i);
        repeat (3) @(negedge clk);
        // R13: reset state
        check(!busy && !irq && !err && !cmd_valid && !per_ack && !mem_req && !stat_req,
              "R13 reset", {busy, irq, err, cmd_valid, per_ack, mem_req, stat_req}, '0);
        rst_n = 1'b1;

        // Chain: contiguous link (R7 +16), jump link, end-of-frame stop.
        build_desc(32'h040, 16'd3, 2'b01, 2'b00, 1, 0, 0, 0, 8'h5A,
                   32'h200, 32'h300, 32'h3F0);
        build_desc(32'h050, 16'd2, 2'b10, 2'b01, 0, 1, 0, 0, 8'h6B,
                   32'h22C, 32'h310, 32'h100);
        build_desc(32'h100, 16'd2, 2'b00, 2'b10, 1, 0, 1, 1, 8'h33,
                   32'h240, 32'h33C, 32'h000);
        pulse_start(32'h040);
        repeat (40) @(negedge clk);
        // R2: nothing moves while the peripheral is not ready
        check(busy && wr_seen == 0 && ack_seen == 0, "R2 stall",
              {32'(wr_seen), 32'(ack_seen)}, '0);
        check(busy, "R12 busy after start", 64'(busy), 64'd1);
        per_req = 1'b1;
        repeat (10) @(negedge clk);
        pulse_start(32'h1C0);   // R12: ignored while busy
        wait_idle();
        repeat (3) @(negedge clk);
        check(!busy, "R8 halted", 64'(busy), 64'd0);
        check(exp_wr_q.size() == 0, "R1/R7 chain writes done",
              64'(exp_wr_q.size()), 64'd0);
        check(exp_cmd_q.size() == 0, "R9 cmd count", 64'(exp_cmd_q.size()), 64'd0);
        check(irq_seen == exp_irq, "R6 irq count", 64'(irq_seen), 64'(exp_irq));
        check(ack_seen == exp_ack, "R2 per_ack count", 64'(ack_seen), 64'(exp_ack));
        check(mem[32'h100 >> 2][31:24] == 8'hC7, "R10 writeback byte",
              64'(mem[32'h100 >> 2]), 64'hC7);
        check(err == 1'b0, "R5 no error yet", 64'(err), 64'd0);

        // R5: reserved source mode holds the address and sets the error.
        build_desc(32'h180, 16'd2, 2'b11, 2'b01, 0, 0, 0, 1, 8'h11,
                   32'h250, 32'h320, 32'h000);
        pulse_start(32'h180);
        wait_idle();
        repeat (3) @(negedge clk);
        check(err == exp_err && err, "R5 sticky error", 64'(err), 64'(exp_err));
        check(exp_wr_q.size() == 0, "R3 reserved as fixed",
              64'(exp_wr_q.size()), 64'd0);
        check(irq_seen == exp_irq, "R6 no irq when bit clear",
              64'(irq_seen), 64'(exp_irq));

        // R11: empty buffer moves nothing but still interrupts.
        build_desc(32'h1C0, 16'd0, 2'b01, 2'b01, 1, 0, 0, 1, 8'h77,
                   32'h260, 32'h330, 32'h000);
        wr_seen = 0;
        pulse_start(32'h1C0);
        wait_idle();
        repeat (3) @(negedge clk);
        check(wr_seen == 0, "R11 no writes", 64'(wr_seen), 64'd0);
        check(exp_cmd_q.size() == 0 && ack_seen == exp_ack, "R11 no word, no cmd",
              64'(ack_seen), 64'(exp_ack));
        check(irq_seen == exp_irq, "R11 irq still given", 64'(irq_seen), 64'(exp_irq));
        check(err, "R5 error held", 64'(err), 64'd1);
        finish_run();
    end
endmodule